// File: doc/BRIEF.md
# Line-Crossing Load Splitter

This block sits between a pipeline's memory stage and a data-cache port. It takes one memory request at a time: a byte address, a size of one to eight bytes and an instruction tag. It then checks whether the bytes spill past the end of a cache line. A load that stays inside one line goes to the cache as a single request. A load that runs over the line end is cut into two requests, and each stays inside its own line. Every cache request carries a one-bit part index. Each response is matched back to its pending part by both tag and index, so the two halves may return in either order.

The returned bytes are gathered in an eight-byte assembly buffer, with the lowest address in the least significant byte. When every part of the load has come back, the block gives one response carrying the original address, the total size, the tag and the right-aligned data. While it waits for cache data with all parts sent, it raises a stall flag. A store that fits in one line is passed straight to the cache. A store that would cross a line is refused and flagged. During a pending load, a store to a line that load is reading is held back if it comes from a different instruction.

Top module: `ls_load_splitter`

## Requirements
- R1: With L the line size, the upper part address is S = (addr + size - 1) rounded down to a multiple of L. A load is split exactly when S > addr. The lower part is then sent at addr with S - addr bytes, and the upper part at S with addr + size - S bytes. An unsplit load is sent as one request at addr with the full size.
- R2: A load's parts go out in order: index 0 first, then index 1. Each is held unchanged on the cache port until the port accepts it, and no part is sent twice.
- R3: A cache response is taken only when its tag equals the pending load's tag and its index names a part that was sent and has not yet returned. Any other response changes neither the result nor the completion.
- R4: In the result, lane b (bits 8b+7:8b) holds the byte at addr + b. Lower-part response byte b goes to lane b. Upper-part response byte b goes to lane (S - addr) + b. Lanes at or above size read zero, and response bytes beyond a part's own size are ignored.
- R5: The combined response is a one-cycle pulse of pipe_rsp_valid in the cycle after the last outstanding part's response is taken. It carries the original address, total size and tag. A split load gives no response after only one part has returned.
- R6: mem_stall is high from the cycle after a load's last part is accepted by the cache until the cycle in which the combined response is given. It is low at all other times.
- R7: A store whose bytes fit in one line is presented on the cache port in the same cycle, with dc_req_we = 1, index 0 and the incoming address, size, tag and write data. A store produces no pipeline response.
- R8: A store that would cross a line is never presented to the cache. It is consumed (pipe_req_ready = 1), and st_cross_err pulses high for one cycle in the next cycle.
- R9: While a load is pending, a store whose line equals a line of one of the load's parts is held back (pipe_req_ready = 0, no cache request) when its tag differs from the load's tag. With the same tag, or to any other line, it is accepted.
- R10: A load is accepted only when no load is pending. At all other times pipe_req_ready is low for a load.
- R11: After reset, there is no cache request, no response, no stall and no error, and a load is ready to be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pipe_req_valid | input | 1 | Pipeline request present |
| pipe_req_ready | output | 1 | Request taken this cycle |
| pipe_req_is_store | input | 1 | 1 = store, 0 = load |
| pipe_req_addr | input | ADDR_W | Byte address |
| pipe_req_size | input | 4 | Size in bytes, 1 to 8 |
| pipe_req_tag | input | TAG_W | Instruction tag |
| pipe_req_wdata | input | 64 | Store data, right-aligned |
| dc_req_valid | output | 1 | Cache request present |
| dc_req_ready | input | 1 | Cache accepts request |
| dc_req_we | output | 1 | 1 = write |
| dc_req_addr | output | ADDR_W | Part start address |
| dc_req_size | output | 4 | Part size in bytes |
| dc_req_tag | output | TAG_W | Instruction tag |
| dc_req_idx | output | 1 | Part index |
| dc_req_wdata | output | 64 | Write data |
| dc_rsp_valid | input | 1 | Cache read data present |
| dc_rsp_tag | input | TAG_W | Tag of returned data |
| dc_rsp_idx | input | 1 | Part index of returned data |
| dc_rsp_data | input | 64 | Part bytes, right-aligned |
| pipe_rsp_valid | output | 1 | Combined load result pulse |
| pipe_rsp_tag | output | TAG_W | Tag of the result |
| pipe_rsp_addr | output | ADDR_W | Original start address |
| pipe_rsp_size | output | 4 | Total size |
| pipe_rsp_data | output | 64 | Assembled data |
| mem_stall | output | 1 | Waiting for cache data |
| st_cross_err | output | 1 | Line-crossing store refused |

## Verification
A wrong split result shows on the cache port in the cycle after a load is taken, as a wrong part address or size. The upper part follows one accepted handshake later. A fault in the part-received bits or the counter shows only when responses come back. It appears either as an early pulse after the first half, or as a missing pulse after the second half with mem_stall stuck high. A misplaced buffer lane shows in the result data in the cycle the pulse appears. The load sweep covers every start offset and size over three small lines, returns the halves in both orders and sends stray responses. Each such fault therefore shows within one load's few cycles.

// File: rtl/ls_pkg.sv
package ls_pkg;
   // widest access in bytes; result bus is right-aligned in this many lanes
   localparam int LS_MAX_BYTES = 8;
   localparam int LS_DATA_W    = 8 * LS_MAX_BYTES;
   localparam int LS_SIZE_W    = $clog2(LS_MAX_BYTES) + 1;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ISS0 = 2'd1,
      ST_ISS1 = 2'd2,
      ST_WAIT = 2'd3
   } ls_state_e;
endpackage

// File: rtl/ls_split_calc.sv
module ls_split_calc #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int SIZE_W     = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output logic              split,
   output logic [ADDR_W-1:0] hi_addr,
   output logic [SIZE_W-1:0] lo_size,
   output logic [SIZE_W-1:0] hi_size
);
   localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

   logic [ADDR_W-1:0] end_addr;
   logic [ADDR_W-1:0] last_byte;

   assign end_addr  = addr + ADDR_W'(size);
   assign last_byte = end_addr - ADDR_W'(1);
   assign hi_addr   = last_byte & ~LINE_MASK;
   assign split     = hi_addr > addr;
   assign lo_size   = split ? SIZE_W'(hi_addr - addr) : size;
   assign hi_size   = split ? SIZE_W'(end_addr - hi_addr) : '0;
endmodule

// File: rtl/ls_conflict.sv
module ls_conflict #(
   parameter int LINE_W = 26,
   parameter int TAG_W  = 4
) (
   input  logic              active,
   input  logic              two_parts,
   input  logic [LINE_W-1:0] own_line0,
   input  logic [LINE_W-1:0] own_line1,
   input  logic [TAG_W-1:0]  own_tag,
   input  logic [LINE_W-1:0] new_line,
   input  logic [TAG_W-1:0]  new_tag,
   output logic              blocked
);
   logic same_line;

   assign same_line = (new_line == own_line0) ||
                      (two_parts && (new_line == own_line1));
   assign blocked   = active && same_line && (new_tag != own_tag);
endmodule

// File: rtl/ls_assemble.sv
module ls_assemble #(
   parameter int NBYTES = 8,
   parameter int SIZE_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic                  wr_lo,
   input  logic                  wr_hi,
   input  logic [SIZE_W-1:0]     lo_size,
   input  logic [SIZE_W-1:0]     total,
   input  logic [8*NBYTES-1:0]   in_data,
   output logic [8*NBYTES-1:0]   out_data
);
   logic [8*NBYTES-1:0] hi_shift;

   // upper part bytes land just above the lower part
   assign hi_shift = in_data << {lo_size, 3'b000};

   for (genvar j = 0; j < NBYTES; j++) begin : g_lane
      localparam logic [SIZE_W-1:0] LANE = SIZE_W'(j);
      logic [7:0] lane_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (clear) begin
            lane_q <= '0;
         end else if (wr_lo && (LANE < lo_size)) begin
            lane_q <= in_data[8*j +: 8];
         end else if (wr_hi && (LANE >= lo_size) && (LANE < total)) begin
            lane_q <= hi_shift[8*j +: 8];
         end
      end

      assign out_data[8*j +: 8] = lane_q;
   end
endmodule

// File: rtl/ls_load_splitter.sv
module ls_load_splitter #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int TAG_W      = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          pipe_req_valid,
   output logic                          pipe_req_ready,
   input  logic                          pipe_req_is_store,
   input  logic [ADDR_W-1:0]             pipe_req_addr,
   input  logic [ls_pkg::LS_SIZE_W-1:0]  pipe_req_size,
   input  logic [TAG_W-1:0]              pipe_req_tag,
   input  logic [ls_pkg::LS_DATA_W-1:0]  pipe_req_wdata,
   output logic                          dc_req_valid,
   input  logic                          dc_req_ready,
   output logic                          dc_req_we,
   output logic [ADDR_W-1:0]             dc_req_addr,
   output logic [ls_pkg::LS_SIZE_W-1:0]  dc_req_size,
   output logic [TAG_W-1:0]              dc_req_tag,
   output logic                          dc_req_idx,
   output logic [ls_pkg::LS_DATA_W-1:0]  dc_req_wdata,
   input  logic                          dc_rsp_valid,
   input  logic [TAG_W-1:0]              dc_rsp_tag,
   input  logic                          dc_rsp_idx,
   input  logic [ls_pkg::LS_DATA_W-1:0]  dc_rsp_data,
   output logic                          pipe_rsp_valid,
   output logic [TAG_W-1:0]              pipe_rsp_tag,
   output logic [ADDR_W-1:0]             pipe_rsp_addr,
   output logic [ls_pkg::LS_SIZE_W-1:0]  pipe_rsp_size,
   output logic [ls_pkg::LS_DATA_W-1:0]  pipe_rsp_data,
   output logic                          mem_stall,
   output logic                          st_cross_err
);
   import ls_pkg::*;

   localparam int SIZE_W = LS_SIZE_W;
   localparam int DATA_W = LS_DATA_W;
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int LINE_W = ADDR_W - OFF_W;

   if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (LINE_BYTES < LS_MAX_BYTES) begin : g_small_line
      $error("LINE_BYTES must be at least the widest access");
   end
   if (LINE_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("TAG_W must be at least 1");
   end

   // incoming request split
   logic              in_split;
   logic [ADDR_W-1:0] in_hi_addr;
   logic [SIZE_W-1:0] in_lo_size;
   logic [SIZE_W-1:0] in_hi_size;

   ls_split_calc #(
      .ADDR_W     (ADDR_W),
      .LINE_BYTES (LINE_BYTES),
      .SIZE_W     (SIZE_W)
   ) u_calc (
      .addr    (pipe_req_addr),
      .size    (pipe_req_size),
      .split   (in_split),
      .hi_addr (in_hi_addr),
      .lo_size (in_lo_size),
      .hi_size (in_hi_size)
   );

   // pending load state
   ls_state_e         state_q;
   logic [ADDR_W-1:0] p_addr;
   logic [ADDR_W-1:0] p_hi_addr;
   logic [SIZE_W-1:0] p_size;
   logic [SIZE_W-1:0] p_lo_size;
   logic [SIZE_W-1:0] p_hi_size;
   logic [TAG_W-1:0]  p_tag;
   logic              p_split;
   logic [1:0]        sent_q;
   logic [1:0]        back_q;
   logic [1:0]        done_cnt;
   logic              rsp_q;
   logic              err_q;

   logic st_blocked;
   logic is_idle;
   logic is_wait;
   logic store_slot;
   logic ld_take;
   logic st_issue;
   logic st_refuse;
   logic hit_lo;
   logic hit_hi;
   logic hit_any;
   logic [1:0] need_cnt;
   logic [1:0] cnt_next;
   logic all_back;

   assign is_idle    = (state_q == ST_IDLE);
   assign is_wait    = (state_q == ST_WAIT);
   assign store_slot = is_idle || is_wait;

   ls_conflict #(
      .LINE_W (LINE_W),
      .TAG_W  (TAG_W)
   ) u_conflict (
      .active    (!is_idle),
      .two_parts (p_split),
      .own_line0 (p_addr[ADDR_W-1:OFF_W]),
      .own_line1 (p_hi_addr[ADDR_W-1:OFF_W]),
      .own_tag   (p_tag),
      .new_line  (pipe_req_addr[ADDR_W-1:OFF_W]),
      .new_tag   (pipe_req_tag),
      .blocked   (st_blocked)
   );

   assign ld_take   = pipe_req_valid && !pipe_req_is_store && is_idle;
   assign st_refuse = pipe_req_valid && pipe_req_is_store && in_split && store_slot;
   assign st_issue  = pipe_req_valid && pipe_req_is_store && !in_split &&
                      store_slot && !st_blocked;

   always_comb begin
      if (pipe_req_is_store) begin
         pipe_req_ready = store_slot && (in_split || (!st_blocked && dc_req_ready));
      end else begin
         pipe_req_ready = is_idle;
      end
   end

   // cache request mux: load parts own the port while being sent
   always_comb begin
      dc_req_valid = 1'b0;
      dc_req_we    = 1'b0;
      dc_req_addr  = pipe_req_addr;
      dc_req_size  = pipe_req_size;
      dc_req_tag   = pipe_req_tag;
      dc_req_idx   = 1'b0;
      dc_req_wdata = '0;
      unique case (state_q)
         ST_ISS0: begin
            dc_req_valid = 1'b1;
            dc_req_addr  = p_addr;
            dc_req_size  = p_lo_size;
            dc_req_tag   = p_tag;
         end
         ST_ISS1: begin
            dc_req_valid = 1'b1;
            dc_req_addr  = p_hi_addr;
            dc_req_size  = p_hi_size;
            dc_req_tag   = p_tag;
            dc_req_idx   = 1'b1;
         end
         default: begin
            dc_req_valid = st_issue;
            dc_req_we    = 1'b1;
            dc_req_wdata = pipe_req_wdata;
         end
      endcase
   end

   // response steering by tag and part index
   assign hit_lo   = dc_rsp_valid && !is_idle && (dc_rsp_tag == p_tag) &&
                     !dc_rsp_idx && sent_q[0] && !back_q[0];
   assign hit_hi   = dc_rsp_valid && !is_idle && (dc_rsp_tag == p_tag) &&
                     dc_rsp_idx && sent_q[1] && !back_q[1];
   assign hit_any  = hit_lo || hit_hi;
   assign need_cnt = p_split ? 2'd2 : 2'd1;
   assign cnt_next = done_cnt + 2'd1;
   assign all_back = hit_any && (cnt_next == need_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         p_addr    <= '0;
         p_hi_addr <= '0;
         p_size    <= '0;
         p_lo_size <= '0;
         p_hi_size <= '0;
         p_tag     <= '0;
         p_split   <= 1'b0;
         sent_q    <= '0;
         back_q    <= '0;
         done_cnt  <= '0;
         rsp_q     <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         rsp_q <= 1'b0;
         err_q <= st_refuse;
         if (hit_any) begin
            done_cnt <= cnt_next;
            if (hit_lo) back_q[0] <= 1'b1;
            if (hit_hi) back_q[1] <= 1'b1;
         end
         unique case (state_q)
            ST_IDLE: begin
               if (ld_take) begin
                  state_q   <= ST_ISS0;
                  p_addr    <= pipe_req_addr;
                  p_hi_addr <= in_hi_addr;
                  p_size    <= pipe_req_size;
                  p_lo_size <= in_lo_size;
                  p_hi_size <= in_hi_size;
                  p_tag     <= pipe_req_tag;
                  p_split   <= in_split;
                  sent_q    <= '0;
                  back_q    <= '0;
                  done_cnt  <= '0;
               end
            end
            ST_ISS0: begin
               if (dc_req_ready) begin
                  sent_q[0] <= 1'b1;
                  state_q   <= p_split ? ST_ISS1 : ST_WAIT;
               end
            end
            ST_ISS1: begin
               if (dc_req_ready) begin
                  sent_q[1] <= 1'b1;
                  state_q   <= ST_WAIT;
               end
            end
            default: begin
               if (all_back) begin
                  state_q <= ST_IDLE;
                  rsp_q   <= 1'b1;
               end
            end
         endcase
      end
   end

   ls_assemble #(
      .NBYTES (LS_MAX_BYTES),
      .SIZE_W (SIZE_W)
   ) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (ld_take),
      .wr_lo    (hit_lo),
      .wr_hi    (hit_hi),
      .lo_size  (p_lo_size),
      .total    (p_size),
      .in_data  (dc_rsp_data),
      .out_data (pipe_rsp_data)
   );

   assign pipe_rsp_valid = rsp_q;
   assign pipe_rsp_tag   = p_tag;
   assign pipe_rsp_addr  = p_addr;
   assign pipe_rsp_size  = p_size;
   assign mem_stall      = is_wait;
   assign st_cross_err   = err_q;

   logic unused_data;
   assign unused_data = ^{DATA_W'(0)};
endmodule

// File: rtl/ls_load_splitter_chk.sv
module ls_load_splitter_chk #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int SIZE_W     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pipe_req_valid,
   input logic              pipe_req_ready,
   input logic              pipe_req_is_store,
   input logic              dc_req_valid,
   input logic              dc_req_ready,
   input logic              dc_req_we,
   input logic [ADDR_W-1:0] dc_req_addr,
   input logic [SIZE_W-1:0] dc_req_size,
   input logic              dc_req_idx,
   input logic              pipe_rsp_valid,
   input logic              mem_stall,
   input logic              st_cross_err
);
   localparam int OFF_W = $clog2(LINE_BYTES);

   logic ld_on_port;
   assign ld_on_port = dc_req_valid && !dc_req_we;

   // R5: combined result is a single-cycle pulse
   a_r5_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_rsp_valid |=> !pipe_rsp_valid);

   // R5: result follows a cycle spent waiting for data
   a_r5_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_rsp_valid |-> $past(mem_stall));

   // R2: a load part waiting for the port stays unchanged
   a_r2_hold_part: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_on_port && !dc_req_ready) |=>
      (ld_on_port && $stable(dc_req_addr) && $stable(dc_req_size) && $stable(dc_req_idx)));

   // R2: upper part only follows a load part on the port
   a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_on_port && dc_req_idx) |-> $past(ld_on_port));

   // R6: no load part is sent while stalled
   a_r6_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      mem_stall |-> !ld_on_port);

   // R10: no load taken while one is pending
   a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_stall && pipe_req_valid && !pipe_req_is_store) |-> !pipe_req_ready);

   // R8: error only after a consumed store
   a_r8_err_src: assert property (@(posedge clk) disable iff (!rst_n)
      st_cross_err |-> $past(pipe_req_valid && pipe_req_is_store && pipe_req_ready));

   // R8: a write on the port never runs past its line
   a_r8_write_in_line: assert property (@(posedge clk) disable iff (!rst_n)
      (dc_req_valid && dc_req_we) |->
      (int'(dc_req_addr[OFF_W-1:0]) + int'(dc_req_size) <= LINE_BYTES));
endmodule

bind ls_load_splitter ls_load_splitter_chk #(
   .ADDR_W     (ADDR_W),
   .LINE_BYTES (LINE_BYTES),
   .SIZE_W     (ls_pkg::LS_SIZE_W)
) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .pipe_req_valid    (pipe_req_valid),
   .pipe_req_ready    (pipe_req_ready),
   .pipe_req_is_store (pipe_req_is_store),
   .dc_req_valid      (dc_req_valid),
   .dc_req_ready      (dc_req_ready),
   .dc_req_we         (dc_req_we),
   .dc_req_addr       (dc_req_addr),
   .dc_req_size       (dc_req_size),
   .dc_req_idx        (dc_req_idx),
   .pipe_rsp_valid    (pipe_rsp_valid),
   .mem_stall         (mem_stall),
   .st_cross_err      (st_cross_err)
);

// File: tb/test_ls_load_splitter.sv
module test_ls_load_splitter;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 16;
   localparam int LINE = 8;
   localparam int TW   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pipe_req_valid = 1'b0;
   logic          pipe_req_ready;
   logic          pipe_req_is_store = 1'b0;
   logic [AW-1:0] pipe_req_addr = '0;
   logic [3:0]    pipe_req_size = '0;
   logic [TW-1:0] pipe_req_tag = '0;
   logic [63:0]   pipe_req_wdata = '0;
   logic          dc_req_valid;
   logic          dc_req_ready = 1'b1;
   logic          dc_req_we;
   logic [AW-1:0] dc_req_addr;
   logic [3:0]    dc_req_size;
   logic [TW-1:0] dc_req_tag;
   logic          dc_req_idx;
   logic [63:0]   dc_req_wdata;
   logic          dc_rsp_valid = 1'b0;
   logic [TW-1:0] dc_rsp_tag = '0;
   logic          dc_rsp_idx = 1'b0;
   logic [63:0]   dc_rsp_data = '0;
   logic          pipe_rsp_valid;
   logic [TW-1:0] pipe_rsp_tag;
   logic [AW-1:0] pipe_rsp_addr;
   logic [3:0]    pipe_rsp_size;
   logic [63:0]   pipe_rsp_data;
   logic          mem_stall;
   logic          st_cross_err;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ls_load_splitter #(.ADDR_W(AW), .LINE_BYTES(LINE), .TAG_W(TW)) i_ls_load_splitter (
      .clk(clk), .rst_n(rst_n),
      .pipe_req_valid(pipe_req_valid), .pipe_req_ready(pipe_req_ready),
      .pipe_req_is_store(pipe_req_is_store), .pipe_req_addr(pipe_req_addr),
      .pipe_req_size(pipe_req_size), .pipe_req_tag(pipe_req_tag),
      .pipe_req_wdata(pipe_req_wdata),
      .dc_req_valid(dc_req_valid), .dc_req_ready(dc_req_ready), .dc_req_we(dc_req_we),
      .dc_req_addr(dc_req_addr), .dc_req_size(dc_req_size), .dc_req_tag(dc_req_tag),
      .dc_req_idx(dc_req_idx), .dc_req_wdata(dc_req_wdata),
      .dc_rsp_valid(dc_rsp_valid), .dc_rsp_tag(dc_rsp_tag), .dc_rsp_idx(dc_rsp_idx),
      .dc_rsp_data(dc_rsp_data),
      .pipe_rsp_valid(pipe_rsp_valid), .pipe_rsp_tag(pipe_rsp_tag),
      .pipe_rsp_addr(pipe_rsp_addr), .pipe_rsp_size(pipe_rsp_size),
      .pipe_rsp_data(pipe_rsp_data), .mem_stall(mem_stall), .st_cross_err(st_cross_err)
   );

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   function automatic logic [7:0] mb(input int a);
      return 8'((a * 37 + 11) ^ (a >> 3));
   endfunction

   function automatic void split_of(input int a, input int sz, output bit sp,
                                    output int sec, output int n0, output int n1);
      sec = ((a + sz - 1) / LINE) * LINE;
      sp  = sec > a;
      n0  = sp ? sec - a : sz;
      n1  = sp ? a + sz - sec : 0;
   endfunction

   function automatic logic [63:0] part_bytes(input int pa, input int pn);
      logic [63:0] d;
      for (int b = 0; b < 8; b++)
         d[8*b +: 8] = (b < pn) ? mb(pa + b) : (8'hE5 ^ 8'(b));
      return d;
   endfunction

   function automatic logic [63:0] load_exp(input int a, input int sz);
      logic [63:0] d;
      for (int b = 0; b < 8; b++)
         d[8*b +: 8] = (b < sz) ? mb(a + b) : 8'h00;
      return d;
   endfunction

   task automatic send_rsp(input int tg, input bit idx, input logic [63:0] d);
      dc_rsp_valid = 1'b1;
      dc_rsp_tag   = TW'(tg);
      dc_rsp_idx   = idx;
      dc_rsp_data  = d;
      @(negedge clk);
      dc_rsp_valid = 1'b0;
      dc_rsp_data  = '0;
   endtask

   // accept a load and watch its parts go out; ends at a negedge in the wait state
   task automatic start_load(input int a, input int sz, input int tg, input int stall);
      bit sp; int sec, n0, n1;
      split_of(a, sz, sp, sec, n0, n1);
      @(negedge clk);
      chk(pipe_req_ready == 1'b1, "R10 load ready when idle", 64'(pipe_req_ready), 64'd1);
      pipe_req_valid    = 1'b1;
      pipe_req_is_store = 1'b0;
      pipe_req_addr     = AW'(a);
      pipe_req_size     = 4'(sz);
      pipe_req_tag      = TW'(tg);
      @(negedge clk);
      pipe_req_valid = 1'b0;
      dc_req_ready   = (stall == 0);
      chk(dc_req_valid && !dc_req_we && !dc_req_idx && dc_req_addr == AW'(a) &&
          dc_req_size == 4'(n0) && dc_req_tag == TW'(tg),
          "R1 lower part", {dc_req_valid, dc_req_idx, 16'(dc_req_addr), 4'(dc_req_size)},
          {1'b1, 1'b0, 16'(a), 4'(n0)});
      for (int s = 0; s < stall; s++) begin
         @(negedge clk);
         chk(dc_req_valid && !dc_req_idx && dc_req_addr == AW'(a),
             "R2 part held while port busy", {dc_req_valid, 16'(dc_req_addr)}, {1'b1, 16'(a)});
         if (s == stall - 1) dc_req_ready = 1'b1;
      end
      if (sp) begin
         @(negedge clk);
         chk(dc_req_valid && !dc_req_we && dc_req_idx && dc_req_addr == AW'(sec) &&
             dc_req_size == 4'(n1), "R1 upper part",
             {dc_req_valid, dc_req_idx, 16'(dc_req_addr), 4'(dc_req_size)},
             {1'b1, 1'b1, 16'(sec), 4'(n1)});
      end
      @(negedge clk);
      chk(!dc_req_valid, "R2 no further part", 64'(dc_req_valid), 64'd0);
      chk(mem_stall && !pipe_rsp_valid, "R6 stall after last part",
          {mem_stall, pipe_rsp_valid}, 2'b10);
   endtask

   task automatic finish_load(input int a, input int sz, input int tg, input bit rev, input bit noise);
      bit sp; int sec, n0, n1; bit first;
      split_of(a, sz, sp, sec, n0, n1);
      first = rev && sp;
      if (noise) begin
         send_rsp((tg + 1) % 16, 1'b0, '1);
         chk(!pipe_rsp_valid && mem_stall, "R3 wrong tag ignored", {pipe_rsp_valid, mem_stall}, 2'b01);
         send_rsp((tg + 1) % 16, 1'b1, '1);
         chk(!pipe_rsp_valid && mem_stall, "R3 wrong tag ignored", {pipe_rsp_valid, mem_stall}, 2'b01);
      end
      send_rsp(tg, first, first ? part_bytes(sec, n1) : part_bytes(a, n0));
      if (sp) begin
         chk(!pipe_rsp_valid && mem_stall, "R5 no result after one half",
             {pipe_rsp_valid, mem_stall}, 2'b01);
         if (noise) begin
            send_rsp(tg, first, '1);
            chk(!pipe_rsp_valid && mem_stall, "R3 repeated half ignored",
                {pipe_rsp_valid, mem_stall}, 2'b01);
         end
         send_rsp(tg, !first, first ? part_bytes(a, n0) : part_bytes(sec, n1));
      end
      chk(pipe_rsp_valid && pipe_rsp_addr == AW'(a) && pipe_rsp_size == 4'(sz) &&
          pipe_rsp_tag == TW'(tg), "R5 result fields",
          {pipe_rsp_valid, 16'(pipe_rsp_addr), 4'(pipe_rsp_size), 4'(pipe_rsp_tag)},
          {1'b1, 16'(a), 4'(sz), 4'(tg)});
      chk(pipe_rsp_data == load_exp(a, sz), "R4 assembled data", pipe_rsp_data, load_exp(a, sz));
      @(negedge clk);
      chk(!pipe_rsp_valid && !mem_stall, "R6 idle after result", {pipe_rsp_valid, mem_stall}, 2'b00);
   endtask

   task automatic try_store(input int a, input int sz, input int tg, input logic [63:0] wd,
                            input bit exp_ready, input bit exp_issue);
      pipe_req_valid    = 1'b1;
      pipe_req_is_store = 1'b1;
      pipe_req_addr     = AW'(a);
      pipe_req_size     = 4'(sz);
      pipe_req_tag      = TW'(tg);
      pipe_req_wdata    = wd;
      #1;
      chk(pipe_req_ready == exp_ready && dc_req_valid == exp_issue, "R9 store gating",
          {pipe_req_ready, dc_req_valid}, {exp_ready, exp_issue});
      if (exp_issue)
         chk(dc_req_we && !dc_req_idx && dc_req_addr == AW'(a) && dc_req_size == 4'(sz) &&
             dc_req_tag == TW'(tg) && dc_req_wdata == wd, "R7 store passed through",
             {dc_req_we, dc_req_idx, 16'(dc_req_addr), 4'(dc_req_size)}, {1'b1, 1'b0, 16'(a), 4'(sz)});
      @(negedge clk);
      pipe_req_valid    = 1'b0;
      pipe_req_is_store = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!dc_req_valid && !pipe_rsp_valid && !mem_stall && !st_cross_err && pipe_req_ready,
          "R11 reset state", {dc_req_valid, pipe_rsp_valid, mem_stall, st_cross_err, pipe_req_ready},
          5'b00001);

      // sweep every offset and size over three lines, both return orders
      for (int a = 0; a < 3 * LINE; a++) begin
         for (int sz = 1; sz <= 8; sz++) begin
            start_load(a, sz, (a + sz) % 16, 0);
            finish_load(a, sz, (a + sz) % 16, ((a ^ sz) & 1) == 1, 1'b0);
         end
      end

      // stray responses on split and unsplit loads
      start_load(5, 6, 2, 0);
      finish_load(5, 6, 2, 1'b0, 1'b1);
      start_load(5, 6, 9, 0);
      finish_load(5, 6, 9, 1'b1, 1'b1);
      start_load(16, 4, 11, 0);
      finish_load(16, 4, 11, 1'b0, 1'b1);

      // port back-pressure on the lower part
      start_load(6, 4, 7, 3);
      finish_load(6, 4, 7, 1'b0, 1'b0);

      // stores when idle
      @(negedge clk);
      try_store(2, 4, 1, 64'h1122_3344_5566_7788, 1'b1, 1'b1);
      chk(!st_cross_err && !pipe_rsp_valid, "R7 store gives no response",
          {st_cross_err, pipe_rsp_valid}, 2'b00);
      @(negedge clk);
      chk(!pipe_rsp_valid, "R7 store gives no response", 64'(pipe_rsp_valid), 64'd0);
      try_store(6, 4, 1, 64'hAA, 1'b1, 1'b0);
      chk(st_cross_err, "R8 crossing store flagged", 64'(st_cross_err), 64'd1);
      @(negedge clk);
      chk(!st_cross_err && !dc_req_valid, "R8 flag one cycle", {st_cross_err, dc_req_valid}, 2'b00);

      // conflicts while a split load (lines 1 and 2) is pending
      start_load(13, 4, 3, 0);
      pipe_req_valid = 1'b1; pipe_req_is_store = 1'b0; pipe_req_addr = AW'(32); pipe_req_size = 4'd1;
      #1;
      chk(!pipe_req_ready, "R10 load refused while pending", 64'(pipe_req_ready), 64'd0);
      @(negedge clk);
      pipe_req_valid = 1'b0;
      try_store(17, 2, 5, 64'h55, 1'b0, 1'b0);
      try_store(9, 2, 5, 64'h66, 1'b0, 1'b0);
      try_store(17, 2, 3, 64'h77, 1'b1, 1'b1);
      try_store(24, 2, 5, 64'h88, 1'b1, 1'b1);
      finish_load(13, 4, 3, 1'b1, 1'b0);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule